// File: doc/BRIEF.md
# Host-to-Microcontroller Command Mailbox

This block is a register-mapped mailbox between a host register port and an embedded microcontroller. Messages go both ways. In the forward direction the host fills a command word and a set of data words, then rings a doorbell. The controller sees the doorbell as a level interrupt. It reads the command from dedicated output buses and clears the doorbell with a one-cycle done pulse once it has consumed the command. While the doorbell is high it also serves as the busy flag. Host writes to the forward payload during that time are dropped and recorded in a sticky overrun bit.

The return direction works the same way with its own handshake. The controller loads a response header and response data words in a single strobe, which raises a level interrupt to the host. The host reads the words back and then writes 0 to the response flag to release the channel. The header packs an echoed opcode, a payload length and an ack code. The block decodes these into a read-only status word, so the host can tell an ack from a nack without shifting fields in software. On a nack the controller places the offending offset in the second response data word.

Top module: `hmc_mailbox`

## Requirements
- R1: A synchronous active-low reset clears every register. After reset every address reads 0, and `ctl_irq` and `host_irq` are low.
- R2: While the doorbell is low, a host write to offset 0 stores the command word and a write to offsets 1..NUM_DATA stores data word 0..NUM_DATA-1. Each stored value reads back at its offset and appears on `ctl_cmd` and `ctl_data` on the next cycle. The opcode sits in `ctl_cmd[7:0]`, and data word i sits in `ctl_data[i*DATA_W +: DATA_W]`.
- R3: A host write with bit 0 set to the control register (offset NUM_DATA+1) sets the doorbell. `ctl_irq` is high from the next cycle, and the control register reads bit 0 = 1.
- R4: A host write of 0 to doorbell bit 0 has no effect. The host cannot clear the doorbell.
- R5: A one-cycle `ctl_done` while the doorbell is high clears it on the next cycle. `ctl_done` while the doorbell is low has no effect.
- R6: A host write to the command or data offsets while the doorbell is high is ignored and sets overrun bit 1 of the control register. The overrun bit stays set until the host writes the control register with bit 1 = 1, and that write does not set the doorbell unless bit 0 is also 1.
- R7: While the response flag is clear, a `ctl_rsp_wr` strobe captures `ctl_rsp_cmd` into the response header (offset NUM_DATA+2) and `ctl_rsp_data` into the response data words (offsets NUM_DATA+3 onward). On the next cycle it sets the response flag, so `host_irq` goes high and `ctl_rsp_ready` goes low.
- R8: A `ctl_rsp_wr` strobe while the response flag is set is ignored. Host writes to the response header or response data offsets have no effect.
- R9: A host write of 0 in bit 0 of the response control register (offset 2*NUM_DATA+3) clears the response flag. A write of 1 there has no effect.
- R10: The status word at offset 2*NUM_DATA+4 decodes the response header. Header bits [9:0] (opcode) read at [25:16], header bits [15:10] (length) read at [13:8], and the ack field in header bits [23:16] reads as bit 0 when it equals 1 (ack) and as bit 1 when it equals 2 (nack). With any other ack value both bits read 0.
- R11: Reads of any offset above 2*NUM_DATA+4 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_addr | input | ADDR_W | Host word offset for read and write |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data, combinational on host_addr |
| host_irq | output | 1 | Response-pending interrupt to the host (level) |
| ctl_irq | output | 1 | Doorbell interrupt to the controller (level) |
| ctl_cmd | output | DATA_W | Forward command word, opcode in [7:0] |
| ctl_data | output | NUM_DATA*DATA_W | Forward data words, word 0 in the low bits |
| ctl_done | input | 1 | Controller pulse that clears the doorbell |
| ctl_rsp_wr | input | 1 | Controller strobe that loads a response |
| ctl_rsp_cmd | input | DATA_W | Response header to load |
| ctl_rsp_data | input | NUM_DATA*DATA_W | Response data words to load |
| ctl_rsp_ready | output | 1 | High when the response channel can accept a strobe |

## Verification
The checks assume that every input holds a defined level from the first clock edge. They also assume that `ctl_done` and `ctl_rsp_wr` are level-sampled strobes that the controller may raise in any cycle, including when they have nothing to act on. The bench therefore sets all inputs to known values before time zero and changes them only on the falling edge. On purpose, it sends `ctl_done` while the doorbell is low, response strobes while the flag is set, and payload writes during busy, so the hold properties see those inputs in both states.

// File: rtl/mbx_pkg.sv
// Shared constants and address helpers for the command mailbox.
// Assumes word addressing; the offset layout is derived from the data-word count.
package mbx_pkg;

    localparam int unsigned ACK_CODE    = 1;
    localparam int unsigned NACK_CODE   = 2;
    localparam int unsigned HDR_OP_LSB  = 0;
    localparam int unsigned HDR_OP_W    = 10;
    localparam int unsigned HDR_LEN_LSB = 10;
    localparam int unsigned HDR_LEN_W   = 6;
    localparam int unsigned HDR_ACK_LSB = 16;
    localparam int unsigned HDR_ACK_W   = 8;
    localparam int unsigned BELL_BIT    = 0;
    localparam int unsigned OVR_BIT     = 1;

    typedef struct packed {
        logic [HDR_OP_W-1:0]  opcode;
        logic [HDR_LEN_W-1:0] length;
        logic                 is_nack;
        logic                 is_ack;
    } rsp_decode_t;

    function automatic int unsigned off_req_cmd();
        return 0;
    endfunction

    function automatic int unsigned off_req_data(int unsigned i);
        return 1 + i;
    endfunction

    function automatic int unsigned off_req_ctrl(int unsigned n);
        return n + 1;
    endfunction

    function automatic int unsigned off_rsp_cmd(int unsigned n);
        return n + 2;
    endfunction

    function automatic int unsigned off_rsp_data(int unsigned n, int unsigned i);
        return n + 3 + i;
    endfunction

    function automatic int unsigned off_rsp_ctrl(int unsigned n);
        return 2 * n + 3;
    endfunction

    function automatic int unsigned off_rsp_stat(int unsigned n);
        return 2 * n + 4;
    endfunction

endpackage

// File: rtl/mbx_req_chan.sv
// Forward (host to controller) channel: command and data registers, the
// doorbell that doubles as the busy flag, and the sticky overrun bit.
// Assumes a single host write port; ctl_done is a level-sampled strobe.
module mbx_req_chan #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_DATA = 3,
    parameter int unsigned ADDR_W   = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic                       done,
    output logic [DATA_W-1:0]          cmd_q,
    output logic [NUM_DATA*DATA_W-1:0] data_q,
    output logic                       bell_q,
    output logic                       ovr_q
);
    import mbx_pkg::*;

    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(off_req_cmd());
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(off_req_ctrl(NUM_DATA));

    logic                hit_cmd;
    logic [NUM_DATA-1:0] hit_data;
    logic                hit_payload;
    logic                hit_ctrl;

    // Decode host writes that target the payload and the control register.
    assign hit_cmd     = wr_en && (addr == A_CMD);
    assign hit_ctrl    = wr_en && (addr == A_CTRL);
    assign hit_payload = hit_cmd || (|hit_data);

    // Command register: loads only while the channel is idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd_q <= '0;
        else if (hit_cmd && !bell_q)
            cmd_q <= wdata;
    end

    generate
        for (genvar gi = 0; gi < NUM_DATA; gi++) begin : g_data
            localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(off_req_data(gi));

            assign hit_data[gi] = wr_en && (addr == A_DATA);

            // Data word gi: loads only while the channel is idle.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    data_q[gi*DATA_W +: DATA_W] <= '0;
                else if (hit_data[gi] && !bell_q)
                    data_q[gi*DATA_W +: DATA_W] <= wdata;
            end
        end
    endgenerate

    // Doorbell: host may only set it, controller may only clear it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bell_q <= 1'b0;
        else if (bell_q && done)
            bell_q <= 1'b0;
        else if (!bell_q && hit_ctrl && wdata[BELL_BIT])
            bell_q <= 1'b1;
    end

    // Overrun: set by a payload write during busy, cleared by host write-one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovr_q <= 1'b0;
        else if (hit_payload && bell_q)
            ovr_q <= 1'b1;
        else if (hit_ctrl && wdata[OVR_BIT])
            ovr_q <= 1'b0;
    end

endmodule

// File: rtl/mbx_rsp_chan.sv
// Return (controller to host) channel: response header and data registers,
// the response flag, and a decode of the packed header fields.
// Assumes the controller loads all response words in one strobe.
module mbx_rsp_chan #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_DATA = 3,
    parameter int unsigned ADDR_W   = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rsp_wr,
    input  logic [DATA_W-1:0]          rsp_cmd_in,
    input  logic [NUM_DATA*DATA_W-1:0] rsp_data_in,
    input  logic                       host_wr_en,
    input  logic [ADDR_W-1:0]          host_addr,
    input  logic                       host_bit0,
    output logic [DATA_W-1:0]          rsp_cmd_q,
    output logic [NUM_DATA*DATA_W-1:0] rsp_data_q,
    output logic                       flag_q,
    output mbx_pkg::rsp_decode_t       decode
);
    import mbx_pkg::*;

    localparam logic [ADDR_W-1:0] A_RCTRL = ADDR_W'(off_rsp_ctrl(NUM_DATA));

    logic load;
    logic release_req;

    // Load only into an empty channel; host releases by writing zero.
    assign load        = rsp_wr && !flag_q;
    assign release_req = host_wr_en && (host_addr == A_RCTRL) && !host_bit0;

    // Response words: captured together on an accepted strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_cmd_q  <= '0;
            rsp_data_q <= '0;
        end else if (load) begin
            rsp_cmd_q  <= rsp_cmd_in;
            rsp_data_q <= rsp_data_in;
        end
    end

    // Response flag: controller sets by loading, host clears by writing 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (load)
            flag_q <= 1'b1;
        else if (release_req)
            flag_q <= 1'b0;
    end

    // Header decode: split opcode, length and classify the ack field.
    always_comb begin
        decode.opcode  = rsp_cmd_q[HDR_OP_LSB +: HDR_OP_W];
        decode.length  = rsp_cmd_q[HDR_LEN_LSB +: HDR_LEN_W];
        decode.is_ack  = (rsp_cmd_q[HDR_ACK_LSB +: HDR_ACK_W] == HDR_ACK_W'(ACK_CODE));
        decode.is_nack = (rsp_cmd_q[HDR_ACK_LSB +: HDR_ACK_W] == HDR_ACK_W'(NACK_CODE));
    end

endmodule

// File: rtl/mbx_rd_mux.sv
// Host read multiplexer over both channels; unmapped offsets read zero.
// Assumes DATA_W is at least 26 so the status word fits.
module mbx_rd_mux #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_DATA = 3,
    parameter int unsigned ADDR_W   = 4
) (
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          req_cmd,
    input  logic [NUM_DATA*DATA_W-1:0] req_data,
    input  logic                       bell,
    input  logic                       ovr,
    input  logic [DATA_W-1:0]          rsp_cmd,
    input  logic [NUM_DATA*DATA_W-1:0] rsp_data,
    input  logic                       rsp_flag,
    input  mbx_pkg::rsp_decode_t       decode,
    output logic [DATA_W-1:0]          rdata
);
    import mbx_pkg::*;

    localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(off_req_cmd());
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(off_req_ctrl(NUM_DATA));
    localparam logic [ADDR_W-1:0] A_RCMD  = ADDR_W'(off_rsp_cmd(NUM_DATA));
    localparam logic [ADDR_W-1:0] A_RCTRL = ADDR_W'(off_rsp_ctrl(NUM_DATA));
    localparam logic [ADDR_W-1:0] A_RSTAT = ADDR_W'(off_rsp_stat(NUM_DATA));

    // Select the register addressed by the host.
    always_comb begin
        rdata = '0;
        if (addr == A_CMD)
            rdata = req_cmd;
        for (int i = 0; i < NUM_DATA; i++) begin
            if (addr == ADDR_W'(off_req_data(i)))
                rdata = req_data[i*DATA_W +: DATA_W];
            if (addr == ADDR_W'(off_rsp_data(NUM_DATA, i)))
                rdata = rsp_data[i*DATA_W +: DATA_W];
        end
        if (addr == A_CTRL) begin
            rdata[BELL_BIT] = bell;
            rdata[OVR_BIT]  = ovr;
        end
        if (addr == A_RCMD)
            rdata = rsp_cmd;
        if (addr == A_RCTRL)
            rdata[0] = rsp_flag;
        if (addr == A_RSTAT) begin
            rdata[0]       = decode.is_ack;
            rdata[1]       = decode.is_nack;
            rdata[13:8]    = decode.length;
            rdata[25:16]   = decode.opcode;
        end
    end

endmodule

// File: rtl/hmc_mailbox.sv
// Two-direction command mailbox top: wires the forward channel, the return
// channel and the host read mux. Interrupt outputs are the raw flag levels.
// Assumes one host write per cycle and strobe-style controller inputs.
module hmc_mailbox #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_DATA = 3,
    parameter int unsigned ADDR_W   = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       host_wr_en,
    input  logic [ADDR_W-1:0]          host_addr,
    input  logic [DATA_W-1:0]          host_wdata,
    output logic [DATA_W-1:0]          host_rdata,
    output logic                       host_irq,
    output logic                       ctl_irq,
    output logic [DATA_W-1:0]          ctl_cmd,
    output logic [NUM_DATA*DATA_W-1:0] ctl_data,
    input  logic                       ctl_done,
    input  logic                       ctl_rsp_wr,
    input  logic [DATA_W-1:0]          ctl_rsp_cmd,
    input  logic [NUM_DATA*DATA_W-1:0] ctl_rsp_data,
    output logic                       ctl_rsp_ready
);
    logic                       bell;
    logic                       ovr;
    logic [DATA_W-1:0]          rsp_cmd_q;
    logic [NUM_DATA*DATA_W-1:0] rsp_data_q;
    logic                       rsp_flag;
    mbx_pkg::rsp_decode_t       decode;

    mbx_req_chan #(.DATA_W(DATA_W), .NUM_DATA(NUM_DATA), .ADDR_W(ADDR_W)) u_req (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (host_wr_en),
        .addr   (host_addr),
        .wdata  (host_wdata),
        .done   (ctl_done),
        .cmd_q  (ctl_cmd),
        .data_q (ctl_data),
        .bell_q (bell),
        .ovr_q  (ovr)
    );

    mbx_rsp_chan #(.DATA_W(DATA_W), .NUM_DATA(NUM_DATA), .ADDR_W(ADDR_W)) u_rsp (
        .clk         (clk),
        .rst_n       (rst_n),
        .rsp_wr      (ctl_rsp_wr),
        .rsp_cmd_in  (ctl_rsp_cmd),
        .rsp_data_in (ctl_rsp_data),
        .host_wr_en  (host_wr_en),
        .host_addr   (host_addr),
        .host_bit0   (host_wdata[0]),
        .rsp_cmd_q   (rsp_cmd_q),
        .rsp_data_q  (rsp_data_q),
        .flag_q      (rsp_flag),
        .decode      (decode)
    );

    mbx_rd_mux #(.DATA_W(DATA_W), .NUM_DATA(NUM_DATA), .ADDR_W(ADDR_W)) u_rd (
        .addr     (host_addr),
        .req_cmd  (ctl_cmd),
        .req_data (ctl_data),
        .bell     (bell),
        .ovr      (ovr),
        .rsp_cmd  (rsp_cmd_q),
        .rsp_data (rsp_data_q),
        .rsp_flag (rsp_flag),
        .decode   (decode),
        .rdata    (host_rdata)
    );

    // Interrupt and ready levels follow the two handshake flags.
    assign ctl_irq       = bell;
    assign host_irq      = rsp_flag;
    assign ctl_rsp_ready = !rsp_flag;

endmodule

// File: rtl/hmc_mailbox_chk.sv
// Protocol checker for the mailbox, attached to every instance by bind.
// Observes ports only; assumes inputs are defined from the first edge.
module hmc_mailbox_chk #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_DATA = 3,
    parameter int unsigned ADDR_W   = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       host_wr_en,
    input logic [ADDR_W-1:0]          host_addr,
    input logic [DATA_W-1:0]          host_wdata,
    input logic [DATA_W-1:0]          host_rdata,
    input logic                       host_irq,
    input logic                       ctl_irq,
    input logic [DATA_W-1:0]          ctl_cmd,
    input logic [NUM_DATA*DATA_W-1:0] ctl_data,
    input logic                       ctl_done,
    input logic                       ctl_rsp_wr
);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(mbx_pkg::off_req_ctrl(NUM_DATA));
    localparam logic [ADDR_W-1:0] A_RCTRL = ADDR_W'(mbx_pkg::off_rsp_ctrl(NUM_DATA));

    logic host_rings;
    logic host_releases;

    assign host_rings    = host_wr_en && (host_addr == A_CTRL) && host_wdata[0];
    assign host_releases = host_wr_en && (host_addr == A_RCTRL) && !host_wdata[0];

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (!ctl_irq && !host_irq && host_rdata == '0)); // R1

    AST_BELL_ONLY_HOST_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_irq && !host_rings) |=> !ctl_irq); // R3

    AST_BELL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_irq && !ctl_done) |=> ctl_irq); // R4

    AST_BELL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_irq && ctl_done) |=> !ctl_irq); // R5

    AST_PAYLOAD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_irq |=> ($stable(ctl_cmd) && $stable(ctl_data))); // R6

    AST_RSP_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_irq && ctl_rsp_wr) |=> host_irq); // R7

    AST_RSP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_irq && !host_releases) |=> host_irq); // R9

endmodule

bind hmc_mailbox hmc_mailbox_chk #(
    .DATA_W(DATA_W), .NUM_DATA(NUM_DATA), .ADDR_W(ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr_en (host_wr_en),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .host_irq   (host_irq),
    .ctl_irq    (ctl_irq),
    .ctl_cmd    (ctl_cmd),
    .ctl_data   (ctl_data),
    .ctl_done   (ctl_done),
    .ctl_rsp_wr (ctl_rsp_wr)
);

// File: tb/hmc_mailbox_bench.sv
// Self-checking bench: a vector table of idle-state writes, then directed
// handshake, overrun, response and reset tests. Inputs change on negedge.
module hmc_mailbox_bench;

    localparam int unsigned DW = 32;
    localparam int unsigned ND = 3;
    localparam int unsigned AW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            host_wr_en = 1'b0;
    logic [AW-1:0]   host_addr = '0;
    logic [DW-1:0]   host_wdata = '0;
    logic [DW-1:0]   host_rdata;
    logic            host_irq;
    logic            ctl_irq;
    logic [DW-1:0]   ctl_cmd;
    logic [ND*DW-1:0] ctl_data;
    logic            ctl_done = 1'b0;
    logic            ctl_rsp_wr = 1'b0;
    logic [DW-1:0]   ctl_rsp_cmd = '0;
    logic [ND*DW-1:0] ctl_rsp_data = '0;
    logic            ctl_rsp_ready;

    int n_chk  = 0;
    int n_fail = 0;
    logic finished = 1'b0;

    always #2.5 clk = ~clk;

    hmc_mailbox #(.DATA_W(DW), .NUM_DATA(ND), .ADDR_W(AW)) u_hmc_mailbox (
        .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_irq(host_irq),
        .ctl_irq(ctl_irq), .ctl_cmd(ctl_cmd), .ctl_data(ctl_data), .ctl_done(ctl_done),
        .ctl_rsp_wr(ctl_rsp_wr), .ctl_rsp_cmd(ctl_rsp_cmd), .ctl_rsp_data(ctl_rsp_data),
        .ctl_rsp_ready(ctl_rsp_ready)
    );

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] expect_rd;
    } vec_t;

    // Idle-state writes and their readback at the same offset.
    localparam vec_t VECS [9] = '{
        '{4'd0,  32'h0000_00A5, 32'h0000_00A5},  // R2 command
        '{4'd1,  32'hDEAD_BEEF, 32'hDEAD_BEEF},  // R2 data 0
        '{4'd2,  32'h1234_5678, 32'h1234_5678},  // R2 data 1
        '{4'd3,  32'hFFFF_FFFF, 32'hFFFF_FFFF},  // R2 data 2
        '{4'd0,  32'h8899_AA20, 32'h8899_AA20},  // R2 command overwrite
        '{4'd4,  32'h0000_0000, 32'h0000_0000},  // R4 doorbell write 0
        '{4'd9,  32'h0000_0001, 32'h0000_0000},  // R9 response flag write 1
        '{4'd5,  32'h5555_5555, 32'h0000_0000},  // R8 response header read-only
        '{4'd12, 32'hCAFE_F00D, 32'h0000_0000}   // R11 unmapped
    };

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        host_wr_en = 1'b1;
        host_addr  = a;
        host_wdata = d;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic host_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic done_pulse();
        @(negedge clk);
        ctl_done = 1'b1;
        @(negedge clk);
        ctl_done = 1'b0;
    endtask

    task automatic rsp_load(input logic [DW-1:0] hdr, input logic [ND*DW-1:0] d);
        @(negedge clk);
        ctl_rsp_wr   = 1'b1;
        ctl_rsp_cmd  = hdr;
        ctl_rsp_data = d;
        @(negedge clk);
        ctl_rsp_wr = 1'b0;
    endtask

    initial begin
        logic [DW-1:0] rd;
        repeat (3) @(negedge clk);
        // R1: all offsets read 0 and both interrupts low after reset.
        for (int a = 0; a < 11; a++) begin
            host_read(AW'(a), rd);
            chk("R1 reset readback", rd, '0);
        end
        chk("R1 ctl_irq after reset", {31'd0, ctl_irq}, 32'd0);
        chk("R1 host_irq after reset", {31'd0, host_irq}, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < 9; i++) begin
            host_write(VECS[i].addr, VECS[i].wdata);
            host_read(VECS[i].addr, rd);
            chk($sformatf("R2 table row %0d", i), rd, VECS[i].expect_rd);
        end

        // R2: controller-side buses carry the stored payload.
        chk("R2 ctl_cmd", ctl_cmd, 32'h8899_AA20);
        chk("R2 ctl_data0", ctl_data[31:0], 32'hDEAD_BEEF);
        chk("R2 ctl_data2", ctl_data[95:64], 32'hFFFF_FFFF);
        chk("R4 no bell from write 0", {31'd0, ctl_irq}, 32'd0);

        // R3: ring the doorbell.
        host_write(4'd4, 32'h1);
        chk("R3 ctl_irq high", {31'd0, ctl_irq}, 32'd1);
        host_read(4'd4, rd);
        chk("R3 ctrl readback", rd, 32'h1);

        // R6: payload write while busy is dropped and flags overrun.
        host_write(4'd0, 32'h0000_0011);
        host_read(4'd0, rd);
        chk("R6 cmd unchanged when busy", rd, 32'h8899_AA20);
        host_write(4'd2, 32'h0BAD_0BAD);
        chk("R6 data1 unchanged when busy", ctl_data[63:32], 32'h1234_5678);
        host_read(4'd4, rd);
        chk("R6 overrun set", rd, 32'h3);

        // R4: host write of 0 cannot clear the doorbell.
        host_write(4'd4, 32'h0);
        chk("R4 bell holds", {31'd0, ctl_irq}, 32'd1);

        // R5: controller done clears; done while idle has no effect.
        done_pulse();
        chk("R5 bell cleared", {31'd0, ctl_irq}, 32'd0);
        done_pulse();
        host_read(4'd4, rd);
        chk("R5 idle done no effect, R6 overrun sticky", rd, 32'h2);

        // R6: write-one to overrun bit clears it without ringing.
        host_write(4'd4, 32'h2);
        host_read(4'd4, rd);
        chk("R6 overrun cleared", rd, 32'h0);
        host_write(4'd0, 32'h0000_0020);
        chk("R2 new command after busy", ctl_cmd, 32'h0000_0020);

        // R7: controller loads an ack response.
        chk("R7 ready before load", {31'd0, ctl_rsp_ready}, 32'd1);
        rsp_load(32'h0001_30A0, {32'h333, 32'h222, 32'h111});
        chk("R7 host_irq high", {31'd0, host_irq}, 32'd1);
        chk("R7 ready low", {31'd0, ctl_rsp_ready}, 32'd0);
        host_read(4'd5, rd);
        chk("R7 header", rd, 32'h0001_30A0);
        host_read(4'd8, rd);
        chk("R7 data2", rd, 32'h333);
        host_read(4'd10, rd);
        chk("R10 ack status", rd, 32'h00A0_0C01);

        // R8: second strobe and host writes leave the response intact.
        rsp_load(32'h0002_0077, {32'h9, 32'h8, 32'h7});
        host_read(4'd5, rd);
        chk("R8 header kept", rd, 32'h0001_30A0);
        host_write(4'd6, 32'hFFFF_0000);
        host_read(4'd6, rd);
        chk("R8 data0 host write ignored", rd, 32'h111);

        // R9: write 1 keeps the flag, write 0 releases it.
        host_write(4'd9, 32'h1);
        chk("R9 flag kept on write 1", {31'd0, host_irq}, 32'd1);
        host_write(4'd9, 32'h0);
        chk("R9 flag cleared", {31'd0, host_irq}, 32'd0);

        // R10: nack with offset in second data word, then an unknown code.
        rsp_load(32'h0002_00A0, {32'h0, 32'h40, 32'h0});
        host_read(4'd10, rd);
        chk("R10 nack status", rd, 32'h00A0_0002);
        host_read(4'd7, rd);
        chk("R10 nack offset", rd, 32'h40);
        host_write(4'd9, 32'h0);
        rsp_load(32'h0003_0000, '0);
        host_read(4'd10, rd);
        chk("R10 unknown code", rd, 32'h0);

        // R1: reset mid-run with both flags set.
        host_write(4'd4, 32'h1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 ctl_irq cleared by reset", {31'd0, ctl_irq}, 32'd0);
        chk("R1 host_irq cleared by reset", {31'd0, host_irq}, 32'd0);
        host_read(4'd0, rd);
        chk("R1 cmd cleared by reset", rd, 32'h0);
        rst_n = 1'b1;

        finished = 1'b1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule